// File: doc/BRIEF.md
# Microoperation-Decoded Accumulator Datapath

This block carries out the register-transfer part of a microprogrammed processor. Each cycle it takes one microinstruction word made of three independent 3-bit operation fields. It decodes each field to a one-hot set of enables and applies every selected transfer at the next rising clock edge. The state it holds is an accumulator, a data register, an address register, a program counter and a word-addressed memory. Next-address sequencing and the control store sit outside the block, and the microinstruction arrives on an input bus.

The block drives the branch conditions combinationally from its registers: the data register's top bit (the indirect flag of a fetched instruction), the accumulator sign and an accumulator-is-zero flag. It also drives the four opcode bits held in the data register, which the sequencer uses for routine mapping. The register contents are visible on outputs for the rest of the processor. Every transfer in a word reads the values held before the edge, so an exchange of accumulator and data register takes one micro-cycle.

Top module: `uop_datapath`

## Requirements
- R1: An active-low asynchronous reset sets the accumulator, data register, address register and program counter to zero.
- R2: The microinstruction word places field A in bits 8:6, field B in bits 5:3 and field C in bits 2:0. A word with 000 in all three fields leaves every register unchanged.
- R3: Field A codes act as follows: 1 adds the data register into the accumulator; 2 clears the accumulator; 3 increments the accumulator; 4 copies the data register to the accumulator; 5 loads the address register from data register bits 10:0; 6 loads the address register from the program counter; 7 writes the data register to memory at the address register.
- R4: Field B codes act as follows: 1 subtracts the data register from the accumulator; 2 ORs the data register into the accumulator; 3 ANDs the data register into the accumulator; 4 loads the data register from memory at the address register; 5 copies the accumulator to the data register; 6 increments the data register; 7 loads data register bits 10:0 from the program counter.
- R5: Field C codes act as follows: 1 XORs the data register into the accumulator; 2 inverts the accumulator; 3 shifts the accumulator left; 4 shifts it right; 5 increments the program counter; 6 loads the program counter from the address register; 7 does nothing.
- R6: Add, subtract and increment results wrap modulo 2^16 (11-bit registers wrap modulo 2^11). Both shifts fill the vacated bit with zero.
- R7: Loading data register bits 10:0 from the program counter leaves data register bits 15:11 unchanged.
- R8: Memory is read combinationally at the address register, and a read captures that word at the clock edge. A write stores the data register into the addressed word at the clock edge.
- R9: All fields act in parallel on pre-edge values. Copying the data register to the accumulator (field A code 4) together with copying the accumulator to the data register (field B code 5) swaps the two registers.
- R10: When two fields of one word write the accumulator, field C overrides field B, and field B overrides field A.
- R11: The outputs follow the registers combinationally: the indirect flag is data register bit 15, the sign flag is accumulator bit 15, the zero flag is high exactly when the accumulator is zero, and the opcode output is data register bits 14:11.
- R12: The word sequence field A code 6, then field B code 4 with field C code 5, then field A code 5 performs an instruction fetch. It ends with the data register holding the word at the old program counter, the program counter advanced by one and the address register holding that word's bits 10:0.
- R13: Reset does not change the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all transfers commit on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the four registers |
| uop | input | 9 | Microinstruction operation fields A, B, C |
| acOut | output | 16 | Accumulator contents |
| drOut | output | 16 | Data register contents |
| arOut | output | 11 | Address register contents |
| pcOut | output | 11 | Program counter contents |
| indirectBit | output | 1 | Data register bit 15 |
| acSign | output | 1 | Accumulator bit 15 |
| acZero | output | 1 | High when the accumulator equals zero |
| opcodeBits | output | 4 | Data register bits 14:11 |

## Verification
The hardest state to reach is a full instruction fetch. Memory can only be loaded through the data register, and the data register can only be built from the accumulator and the program counter. The stimulus therefore builds an instruction word with a set indirect bit and a nonzero opcode from scratch: it inverts and shifts a cleared accumulator, sums two shifted copies, splices program-counter bits into the low field and stores the result at the program counter's address. After clearing the data and address registers, it runs the three fetch words. A second hard case is checking the field override order. Words that put two or three accumulator operations in the same cycle are run from accumulator and data register values chosen so that each operation gives a different result.

// File: rtl/uop_pkg.sv
package uop_pkg;

  localparam int FIELD_W = 3;
  localparam int NUM_FIELDS = 3;

  typedef enum logic [3:0] {
    AC_HOLD, AC_ADD, AC_CLR, AC_INC, AC_LOAD_DR, AC_SUB,
    AC_OR, AC_AND, AC_XOR, AC_NOT, AC_SHL, AC_SHR
  } acOpE;

  typedef enum logic [2:0] {
    DR_HOLD, DR_MEM, DR_AC, DR_INC, DR_PCLOW
  } drOpE;

  typedef enum logic [1:0] {
    AR_HOLD, AR_DRLOW, AR_PC
  } arOpE;

  typedef enum logic [1:0] {
    PC_HOLD, PC_INC, PC_AR
  } pcOpE;

  typedef struct packed {
    acOpE acOp;
    drOpE drOp;
    arOpE arOp;
    pcOpE pcOp;
    logic memWr;
  } strobeT;

endpackage

// File: rtl/uop_decode.sv
module uop_decode
  import uop_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic [NUM_FIELDS*FW-1:0] uop,
  output strobeT                   strobes
);

  localparam int NCODE = 1 << FW;

  logic [NCODE-1:0] fieldHot [NUM_FIELDS];

  // field index 0 is A (top bits), 1 is B, 2 is C
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [FW-1:0] fieldVal;
    assign fieldVal = uop[(NUM_FIELDS-1-f)*FW +: FW];
    for (genvar k = 0; k < NCODE; k++) begin : g_code
      assign fieldHot[f][k] = (fieldVal == FW'(k));
    end
  end

  always_comb begin
    strobes = '0;
    // field A: lowest accumulator priority, evaluated first
    case (1'b1)
      fieldHot[0][0]: ;
      fieldHot[0][1]: strobes.acOp = AC_ADD;
      fieldHot[0][2]: strobes.acOp = AC_CLR;
      fieldHot[0][3]: strobes.acOp = AC_INC;
      fieldHot[0][4]: strobes.acOp = AC_LOAD_DR;
      fieldHot[0][5]: strobes.arOp = AR_DRLOW;
      fieldHot[0][6]: strobes.arOp = AR_PC;
      fieldHot[0][7]: strobes.memWr = 1'b1;
      default: ;
    endcase
    // field B overrides field A on the accumulator (R10)
    case (1'b1)
      fieldHot[1][0]: ;
      fieldHot[1][1]: strobes.acOp = AC_SUB;
      fieldHot[1][2]: strobes.acOp = AC_OR;
      fieldHot[1][3]: strobes.acOp = AC_AND;
      fieldHot[1][4]: strobes.drOp = DR_MEM;
      fieldHot[1][5]: strobes.drOp = DR_AC;
      fieldHot[1][6]: strobes.drOp = DR_INC;
      fieldHot[1][7]: strobes.drOp = DR_PCLOW;
      default: ;
    endcase
    // field C overrides both on the accumulator; code 7 is a no-op (R5)
    case (1'b1)
      fieldHot[2][0]: ;
      fieldHot[2][1]: strobes.acOp = AC_XOR;
      fieldHot[2][2]: strobes.acOp = AC_NOT;
      fieldHot[2][3]: strobes.acOp = AC_SHL;
      fieldHot[2][4]: strobes.acOp = AC_SHR;
      fieldHot[2][5]: strobes.pcOp = PC_INC;
      fieldHot[2][6]: strobes.pcOp = PC_AR;
      fieldHot[2][7]: ;
      default: ;
    endcase
  end

endmodule

// File: rtl/uop_regs.sv
module uop_regs
  import uop_pkg::*;
#(
  parameter int AW  = 11,
  parameter int DW  = 16,
  parameter int OPW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strobes,
  output logic [DW-1:0] ac,
  output logic [DW-1:0] dr,
  output logic [AW-1:0] ar,
  output logic [AW-1:0] pc,
  output logic          acZero
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] memRd;
  logic [DW-1:0] acNext, drNext;
  logic [AW-1:0] arNext, pcNext;

  assign memRd  = mem[ar];
  assign acZero = (ac == '0);

  always_comb begin
    case (strobes.acOp)
      AC_ADD:     acNext = ac + dr;
      AC_CLR:     acNext = '0;
      AC_INC:     acNext = ac + DW'(1);
      AC_LOAD_DR: acNext = dr;
      AC_SUB:     acNext = ac - dr;
      AC_OR:      acNext = ac | dr;
      AC_AND:     acNext = ac & dr;
      AC_XOR:     acNext = ac ^ dr;
      AC_NOT:     acNext = ~ac;
      AC_SHL:     acNext = {ac[DW-2:0], 1'b0};
      AC_SHR:     acNext = {1'b0, ac[DW-1:1]};
      default:    acNext = ac;
    endcase
  end

  always_comb begin
    case (strobes.drOp)
      DR_MEM:   drNext = memRd;
      DR_AC:    drNext = ac;
      DR_INC:   drNext = dr + DW'(1);
      DR_PCLOW: drNext = {dr[DW-1:AW], pc};
      default:  drNext = dr;
    endcase
  end

  always_comb begin
    case (strobes.arOp)
      AR_DRLOW: arNext = dr[AW-1:0];
      AR_PC:    arNext = pc;
      default:  arNext = ar;
    endcase
  end

  always_comb begin
    case (strobes.pcOp)
      PC_INC:  pcNext = pc + AW'(1);
      PC_AR:   pcNext = ar;
      default: pcNext = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ac <= '0;
      dr <= '0;
      ar <= '0;
      pc <= '0;
    end else begin
      ac <= acNext;
      dr <= drNext;
      ar <= arNext;
      pc <= pcNext;
    end
  end

  // memory is outside the reset domain (R13)
  always_ff @(posedge clk) begin
    if (strobes.memWr) mem[ar] <= dr;
  end

  initial begin
    assert (DW > AW + OPW) else $error("data width too small for instruction layout");
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> ($stable(ac) && $stable(dr) && $stable(ar) && $stable(pc)));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.acOp == AC_CLR) |=> acZero);

  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pcOp == PC_INC) |=> (pc == $past(pc) + AW'(1)));

  assert_pclow_keeps_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.drOp == DR_PCLOW) |=> (dr[DW-1:AW] == $past(dr[DW-1:AW])));

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWr |=> (mem[$past(ar)] == $past(dr)));

  assert_exchange_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.acOp == AC_LOAD_DR && strobes.drOp == DR_AC)
      |=> (ac == $past(dr) && dr == $past(ac)));

endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int AW  = 11,
  parameter int DW  = 16,
  parameter int OPW = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_FIELDS*FIELD_W-1:0]  uop,
  output logic [DW-1:0]                  acOut,
  output logic [DW-1:0]                  drOut,
  output logic [AW-1:0]                  arOut,
  output logic [AW-1:0]                  pcOut,
  output logic                           indirectBit,
  output logic                           acSign,
  output logic                           acZero,
  output logic [OPW-1:0]                 opcodeBits
);

  strobeT strobes;

  uop_decode #(.FW(FIELD_W)) u_decode (
    .uop     (uop),
    .strobes (strobes)
  );

  uop_regs #(.AW(AW), .DW(DW), .OPW(OPW)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ac      (acOut),
    .dr      (drOut),
    .ar      (arOut),
    .pc      (pcOut),
    .acZero  (acZero)
  );

  assign indirectBit = drOut[DW-1];
  assign acSign      = acOut[DW-1];
  assign opcodeBits  = drOut[DW-2 -: OPW];

endmodule

// File: tb/uop_datapath_tb.sv
module uop_datapath_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  typedef struct packed {
    logic [8:0]  uop;
    logic [15:0] ac;
    logic [15:0] dr;
    logic [10:0] ar;
    logic [10:0] pc;
    logic [3:0]  req;
  } vecT;

  // uop written in octal: one digit per field A, B, C
  localparam vecT VEC [NVEC] = '{
    '{9'o300, 16'h0001, 16'h0000, 11'd0, 11'd0, 4'd3},  // R3 inc ac
    '{9'o065, 16'h0001, 16'h0001, 11'd0, 11'd1, 4'd4},  // R4 inc dr, R5 inc pc
    '{9'o100, 16'h0002, 16'h0001, 11'd0, 11'd1, 4'd3},  // R3 add
    '{9'o003, 16'h0004, 16'h0001, 11'd0, 11'd1, 4'd5},  // R5 shl
    '{9'o010, 16'h0003, 16'h0001, 11'd0, 11'd1, 4'd4},  // R4 sub
    '{9'o600, 16'h0003, 16'h0001, 11'd1, 11'd1, 4'd3},  // R3 ar<-pc
    '{9'o055, 16'h0003, 16'h0003, 11'd1, 11'd2, 4'd4},  // R4 dr<-ac
    '{9'o700, 16'h0003, 16'h0003, 11'd1, 11'd2, 4'd8},  // R8 write M[1]=3
    '{9'o270, 16'h0000, 16'h0002, 11'd1, 11'd2, 4'd7},  // R7 clr + dr low<-pc
    '{9'o040, 16'h0000, 16'h0003, 11'd1, 11'd2, 4'd8},  // R8 read M[1]
    '{9'o002, 16'hFFFF, 16'h0003, 11'd1, 11'd2, 4'd5},  // R5 invert
    '{9'o004, 16'h7FFF, 16'h0003, 11'd1, 11'd2, 4'd6},  // R6 shr zero fill
    '{9'o030, 16'h0003, 16'h0003, 11'd1, 11'd2, 4'd4},  // R4 and
    '{9'o001, 16'h0000, 16'h0003, 11'd1, 11'd2, 4'd5},  // R5 xor
    '{9'o020, 16'h0003, 16'h0003, 11'd1, 11'd2, 4'd4},  // R4 or
    '{9'o500, 16'h0003, 16'h0003, 11'd3, 11'd2, 4'd3},  // R3 ar<-dr low
    '{9'o006, 16'h0003, 16'h0003, 11'd3, 11'd3, 4'd5},  // R5 pc<-ar
    '{9'o007, 16'h0003, 16'h0003, 11'd3, 11'd3, 4'd5},  // R5 reserved no-op
    '{9'o303, 16'h0006, 16'h0003, 11'd3, 11'd3, 4'd10}, // R10 C beats A
    '{9'o112, 16'hFFF9, 16'h0003, 11'd3, 11'd3, 4'd10}, // R10 C beats B and A
    '{9'o320, 16'hFFFB, 16'h0003, 11'd3, 11'd3, 4'd10}, // R10 B beats A
    '{9'o450, 16'h0003, 16'hFFFB, 11'd3, 11'd3, 4'd9},  // R9 exchange
    '{9'o060, 16'h0003, 16'hFFFC, 11'd3, 11'd3, 4'd4},  // R4 inc dr
    '{9'o100, 16'hFFFF, 16'hFFFC, 11'd3, 11'd3, 4'd11}, // R11 sign set
    '{9'o300, 16'h0000, 16'hFFFC, 11'd3, 11'd3, 4'd6},  // R6 inc wraps, zero flag
    '{9'o070, 16'h0000, 16'hF803, 11'd3, 11'd3, 4'd7},  // R7 top bits kept
    '{9'o010, 16'h07FD, 16'hF803, 11'd3, 11'd3, 4'd6}   // R6 sub wraps
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  uop = '0;
  logic [15:0] acOut, drOut;
  logic [10:0] arOut, pcOut;
  logic        indirectBit, acSign, acZero;
  logic [3:0]  opcodeBits;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_datapath u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .uop         (uop),
    .acOut       (acOut),
    .drOut       (drOut),
    .arOut       (arOut),
    .pcOut       (pcOut),
    .indirectBit (indirectBit),
    .acSign      (acSign),
    .acZero      (acZero),
    .opcodeBits  (opcodeBits)
  );

  // compares registers and the R11 flags derived from the expected registers
  task automatic checkState(input string tag, input logic [15:0] eAc, input logic [15:0] eDr,
                            input logic [10:0] eAr, input logic [10:0] ePc);
    logic [7:0] eFlags, aFlags;
    eFlags = {eDr[15], eAc[15], (eAc == 16'h0), 1'b0, eDr[14:11]};
    aFlags = {indirectBit, acSign, acZero, 1'b0, opcodeBits};
    total++;
    if (acOut !== eAc || drOut !== eDr || arOut !== eAr || pcOut !== ePc || aFlags !== eFlags) begin
      bad++;
      $display("FAIL %s: ac=%h dr=%h ar=%h pc=%h flags=%h expected ac=%h dr=%h ar=%h pc=%h flags=%h",
               tag, acOut, drOut, arOut, pcOut, aFlags, eAc, eDr, eAr, ePc, eFlags);
    end
  endtask

  // drive at a falling edge, commit at the rising edge, check at the next falling edge
  task automatic step(input logic [8:0] w, input string tag, input logic [15:0] eAc,
                      input logic [15:0] eDr, input logic [10:0] eAr, input logic [10:0] ePc);
    uop = w;
    @(negedge clk);
    checkState(tag, eAc, eDr, eAr, ePc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    checkState("R1 reset state", 16'h0, 16'h0, 11'd0, 11'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].uop, $sformatf("R%0d vector %0d", VEC[i].req, i),
           VEC[i].ac, VEC[i].dr, VEC[i].ar, VEC[i].pc);
    end

    // R1: reset in mid-run clears the registers without a clock edge
    uop = 9'o000;
    rstN = 1'b0;
    #1;
    checkState("R1 async reset", 16'h0, 16'h0, 11'd0, 11'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R13: word 1 still holds 3 after reset
    step(9'o005, "R5 pc inc", 16'h0, 16'h0, 11'd0, 11'd1);
    step(9'o600, "R3 ar<-pc", 16'h0, 16'h0, 11'd1, 11'd1);
    step(9'o040, "R13 memory kept over reset", 16'h0, 16'h0003, 11'd1, 11'd1);

    // build instruction C005 (indirect set, opcode 1000, address 5) at word 5
    step(9'o002, "R5 invert", 16'hFFFF, 16'h0003, 11'd1, 11'd1);
    step(9'o004, "R6 shr", 16'h7FFF, 16'h0003, 11'd1, 11'd1);
    step(9'o002, "R5 invert", 16'h8000, 16'h0003, 11'd1, 11'd1);
    step(9'o050, "R4 dr<-ac", 16'h8000, 16'h8000, 11'd1, 11'd1);
    step(9'o004, "R6 shr", 16'h4000, 16'h8000, 11'd1, 11'd1);
    step(9'o100, "R3 add", 16'hC000, 16'h8000, 11'd1, 11'd1);
    step(9'o050, "R4 dr<-ac", 16'hC000, 16'hC000, 11'd1, 11'd1);
    for (int k = 2; k <= 5; k++) begin
      step(9'o005, "R5 pc inc", 16'hC000, 16'hC000, 11'd1, 11'(k));
    end
    step(9'o070, "R7 dr low<-pc", 16'hC000, 16'hC005, 11'd1, 11'd5);
    step(9'o600, "R3 ar<-pc", 16'hC000, 16'hC005, 11'd5, 11'd5);
    step(9'o700, "R8 write word 5", 16'hC000, 16'hC005, 11'd5, 11'd5);
    step(9'o200, "R3 clear ac", 16'h0000, 16'hC005, 11'd5, 11'd5);
    step(9'o050, "R4 dr<-ac", 16'h0000, 16'h0000, 11'd5, 11'd5);
    step(9'o500, "R3 ar<-dr low", 16'h0000, 16'h0000, 11'd0, 11'd5);

    // R12 fetch sequence
    step(9'o600, "R12 fetch 1", 16'h0000, 16'h0000, 11'd5, 11'd5);
    step(9'o045, "R12 fetch 2", 16'h0000, 16'hC005, 11'd5, 11'd6);
    step(9'o500, "R12 fetch 3", 16'h0000, 16'hC005, 11'd5, 11'd6);

    // R2: all-zero word holds everything
    step(9'o000, "R2 idle word", 16'h0000, 16'hC005, 11'd5, 11'd6);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule